// File: doc/BRIEF.md
# Video Memory Fetch and Pixel Expansion Unit

This block reads one display line of video memory through a simple read port and turns the bytes into a stream of pixel colour codes. It runs only when started. Each memory read happens in a slot the block owns, so the CPU never waits on it. A line controller gives it a base address, a unit count, a display mode, the glyph row and the glyph height, and then pulses `start_i`. The block walks the line and reports each pixel on `pix_valid_o`. Each pixel goes either on an 8-bit direct colour bus or on a 3-bit palette index bus, and `pix_sel_o` says which of the two colour paths applies.

There are three modes. In low-res mode every byte is one 256-colour pixel. In high-res mode every byte holds two 8-colour pixels. In text mode the bytes come in pairs: an attribute byte, then a character code. The code and the glyph row address a glyph ROM, and the returned glyph byte is shifted out as eight pixels. Each pixel takes the foreground or the background colour from the attribute.

The sequencer has these states: `ST_IDLE`, `ST_ATTR` (read the attribute), `ST_CODE` (latch the attribute, read the code), `ST_GLYPH` (issue the glyph ROM read), `ST_LOAD` (load the glyph shifter), `ST_SHIFT` (8 pixel cycles), `ST_BYTE` (read a bitmap byte), `ST_PIXA` (first pixel of a byte) and `ST_PIXB` (second high-res pixel).
- From `ST_IDLE`, an accepted start goes to `ST_ATTR` in text mode and to `ST_BYTE` in any other mode.
- In text mode the path is `ST_ATTR`→`ST_CODE`→`ST_GLYPH`→`ST_LOAD`→`ST_SHIFT`. After the eighth shift cycle the FSM goes back to `ST_ATTR`, or to `ST_IDLE` after the last cell.
- In bitmap modes the path is `ST_BYTE`→`ST_PIXA`. In high-res mode it continues `ST_PIXA`→`ST_PIXB`. The FSM then returns to `ST_BYTE`, or to `ST_IDLE` after the last byte.

Top module: `vfetch_top`

## Requirements
- R1: After reset, `busy_o`, `pix_valid_o`, `mem_rd_o` and `font_rd_o` are all 0.
- R2: A start pulse seen in idle with a nonzero `len_i` makes `busy_o` rise on the next clock. A start with `len_i`=0 does nothing: no reads and no busy. A start seen while busy is ignored, and the line in progress is not disturbed.
- R3: Low-res mode emits one pixel per byte, reading address base+k for byte k. The pixel has `pix_sel_o`=0, `pix_rgb_o` equal to the byte (red [7:5], green [4:2], blue [1:0]) and `pix_idx_o`=0. Each byte takes 2 clocks of busy.
- R4: High-res mode emits two pixels per byte. The upper nibble comes first. Each pixel's index is bits [2:0] of its nibble. Both pixels have `pix_sel_o`=1 and `pix_rgb_o`=0. Each byte takes 3 clocks of busy.
- R5: In text mode, cell k reads its attribute at base+2k and its code at base+2k+1. It emits 8 pixels from the glyph byte, MSB first. A 1 bit gives attribute bits [6:4] (foreground) and a 0 bit gives bits [2:0] (background). All 8 pixels have `pix_sel_o`=1.
- R6: The glyph ROM address is {code, g}, where g is `row_i`[3:0] when `tall_i`=1 and {0, `row_i`[2:0]} when `tall_i`=0. The glyph ROM returns its data one clock after `font_rd_o`. Both `row_i` and `tall_i` are sampled at the accepted start.
- R7: A text cell keeps `busy_o` high for exactly 12 clocks, and its 8 pixels come on consecutive clocks. A pixel never appears in the cycle right after a glyph read.
- R8: Mode codes are 00 low-res, 01 text and 10 high-res. Code 11 behaves as low-res. The mode is sampled at the accepted start.
- R9: Video memory returns data one clock after `mem_rd_o`. At most one read port is active per clock. Video reads occur only while busy, and each address of the line is read exactly once, in ascending order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous release |
| start_i | input | 1 | Begin a line |
| mode_i | input | 2 | Display mode code |
| len_i | input | 8 | Bytes (bitmap) or cells (text) in the line |
| base_i | input | 16 | First video memory address of the line |
| row_i | input | 4 | Row inside the glyph cell |
| tall_i | input | 1 | 1: 16-row glyphs, 0: 8-row glyphs |
| mem_rd_o | output | 1 | Video memory read strobe |
| mem_addr_o | output | 16 | Video memory address |
| mem_data_i | input | 8 | Video memory data, one clock after the strobe |
| font_rd_o | output | 1 | Glyph ROM read strobe |
| font_addr_o | output | 12 | Glyph ROM address {code, row} |
| font_data_i | input | 8 | Glyph ROM data, one clock after the strobe |
| busy_o | output | 1 | Line in progress |
| pix_valid_o | output | 1 | Pixel present this clock |
| pix_sel_o | output | 1 | 0: direct colour path, 1: palette index path |
| pix_rgb_o | output | 8 | Direct 256-colour pixel |
| pix_idx_o | output | 3 | 8-colour palette index |

## Verification
The hardest situation to reach is a second start arriving mid-line. It comes together with new mode, base, row and height values while an earlier text line is still being expanded. The block must keep the values it sampled, and it must not restart or skip a cell. The bench drives this in a dedicated task: three clocks into a text line it pulses start and swaps every line parameter. It then checks that the pixel stream, the read address order, the glyph addresses and the busy length all match the original line. A separate zero-length start checks that no read is issued.

// File: rtl/vfetch_pkg.sv
package vfetch_pkg;

    typedef enum logic [1:0] {
        VM_LORES = 2'b00,
        VM_TEXT  = 2'b01,
        VM_HIRES = 2'b10,
        VM_ALT   = 2'b11
    } vmode_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ATTR,
        ST_CODE,
        ST_GLYPH,
        ST_LOAD,
        ST_SHIFT,
        ST_BYTE,
        ST_PIXA,
        ST_PIXB
    } vstate_e;

    localparam int GLYPH_W   = 8;
    localparam int GROW_W    = 4;
    localparam int COLOUR_W  = 3;

    function automatic logic [GROW_W-1:0] glyph_row(input logic [GROW_W-1:0] row,
                                                    input logic tall);
        return tall ? row : {1'b0, row[GROW_W-2:0]};
    endfunction

endpackage

// File: rtl/vfetch_seq.sv
module vfetch_seq
    import vfetch_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int LEN_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [1:0]        mode_i,
    input  logic [LEN_W-1:0]  len_i,
    input  logic [ADDR_W-1:0] base_i,
    output vstate_e           state_o,
    output logic              hires_o,
    output logic              accept_o,
    output logic              mem_rd_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              busy_o
);

    localparam int BIT_W = $clog2(GLYPH_W);
    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(GLYPH_W - 1);

    vstate_e           state_q, state_d;
    vmode_e            mode_q;
    logic [LEN_W-1:0]  left_q;
    logic [ADDR_W-1:0] ptr_q;
    logic [BIT_W-1:0]  bit_q;
    logic              last_unit;
    logic              unit_done;

    assign accept_o  = (state_q == ST_IDLE) && start_i && (len_i != '0);
    assign last_unit = (left_q == LEN_W'(1));
    assign hires_o   = (mode_q == VM_HIRES);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept_o) begin
                    state_d = (vmode_e'(mode_i) == VM_TEXT) ? ST_ATTR : ST_BYTE;
                end
            end
            ST_ATTR:  state_d = ST_CODE;
            ST_CODE:  state_d = ST_GLYPH;
            ST_GLYPH: state_d = ST_LOAD;
            ST_LOAD:  state_d = ST_SHIFT;
            ST_SHIFT: begin
                if (bit_q == BIT_LAST) begin
                    state_d = last_unit ? ST_IDLE : ST_ATTR;
                end
            end
            ST_BYTE:  state_d = ST_PIXA;
            ST_PIXA: begin
                if (hires_o) begin
                    state_d = ST_PIXB;
                end else begin
                    state_d = last_unit ? ST_IDLE : ST_BYTE;
                end
            end
            ST_PIXB:  state_d = last_unit ? ST_IDLE : ST_BYTE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // outputs of the sequencer
    always_comb begin
        mem_rd_o = 1'b0;
        busy_o   = 1'b1;
        unit_done = 1'b0;
        unique case (state_q)
            ST_IDLE:  busy_o = 1'b0;
            ST_ATTR,
            ST_CODE,
            ST_BYTE:  mem_rd_o = 1'b1;
            ST_SHIFT: unit_done = (bit_q == BIT_LAST);
            ST_PIXA:  unit_done = !hires_o;
            ST_PIXB:  unit_done = 1'b1;
            default:  ;
        endcase
    end

    assign mem_addr_o = ptr_q;
    assign state_o    = state_q;

    // line bookkeeping: mode, remaining units, address pointer, bit counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= VM_LORES;
            left_q <= '0;
            ptr_q  <= '0;
            bit_q  <= '0;
        end else begin
            if (accept_o) begin
                mode_q <= vmode_e'(mode_i);
                left_q <= len_i;
                ptr_q  <= base_i;
            end else begin
                if (mem_rd_o) begin
                    ptr_q <= ptr_q + ADDR_W'(1);
                end
                if (unit_done) begin
                    left_q <= left_q - LEN_W'(1);
                end
            end
            if (state_q == ST_LOAD) begin
                bit_q <= '0;
            end else if (state_q == ST_SHIFT) begin
                bit_q <= bit_q + BIT_W'(1);
            end
        end
    end

endmodule

// File: rtl/vfetch_text.sv
module vfetch_text
    import vfetch_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  vstate_e              state_i,
    input  logic                 accept_i,
    input  logic [GROW_W-1:0]    row_i,
    input  logic                 tall_i,
    input  logic [7:0]           mem_data_i,
    output logic                 font_rd_o,
    output logic [7+GROW_W:0]    font_addr_o,
    input  logic [GLYPH_W-1:0]   font_data_i,
    output logic [COLOUR_W-1:0]  idx_o
);

    logic [GROW_W-1:0]   grow_q;
    logic [COLOUR_W-1:0] fg_q, bg_q;
    logic [GLYPH_W-1:0]  shift_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            grow_q  <= '0;
            fg_q    <= '0;
            bg_q    <= '0;
            shift_q <= '0;
        end else begin
            if (accept_i) begin
                grow_q <= glyph_row(row_i, tall_i);
            end
            unique case (state_i)
                ST_CODE:  begin
                    fg_q <= mem_data_i[6:4];
                    bg_q <= mem_data_i[2:0];
                end
                ST_LOAD:  shift_q <= font_data_i;
                ST_SHIFT: shift_q <= {shift_q[GLYPH_W-2:0], 1'b0};
                default:  ;
            endcase
        end
    end

    always_comb begin
        font_rd_o   = (state_i == ST_GLYPH);
        font_addr_o = {mem_data_i, grow_q};
        idx_o       = shift_q[GLYPH_W-1] ? fg_q : bg_q;
    end

endmodule

// File: rtl/vfetch_bitmap.sv
module vfetch_bitmap
    import vfetch_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  vstate_e             state_i,
    input  logic [COLOUR_W-1:0] hi_i,
    input  logic [COLOUR_W-1:0] lo_i,
    output logic [COLOUR_W-1:0] idx_o
);

    logic [COLOUR_W-1:0] lo_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q <= '0;
        end else if (state_i == ST_PIXA) begin
            lo_q <= lo_i;
        end
    end

    always_comb begin
        idx_o = (state_i == ST_PIXB) ? lo_q : hi_i;
    end

endmodule

// File: rtl/vfetch_top.sv
module vfetch_top
    import vfetch_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int LEN_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [1:0]        mode_i,
    input  logic [LEN_W-1:0]  len_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [3:0]        row_i,
    input  logic              tall_i,
    output logic              mem_rd_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    input  logic [7:0]        mem_data_i,
    output logic              font_rd_o,
    output logic [11:0]       font_addr_o,
    input  logic [7:0]        font_data_i,
    output logic              busy_o,
    output logic              pix_valid_o,
    output logic              pix_sel_o,
    output logic [7:0]        pix_rgb_o,
    output logic [2:0]        pix_idx_o
);

    vstate_e             state;
    logic                hires;
    logic                accept;
    logic [COLOUR_W-1:0] text_idx;
    logic [COLOUR_W-1:0] bm_idx;

    vfetch_seq #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) i_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .mode_i     (mode_i),
        .len_i      (len_i),
        .base_i     (base_i),
        .state_o    (state),
        .hires_o    (hires),
        .accept_o   (accept),
        .mem_rd_o   (mem_rd_o),
        .mem_addr_o (mem_addr_o),
        .busy_o     (busy_o)
    );

    vfetch_text i_text (
        .clk         (clk),
        .rst_n       (rst_n),
        .state_i     (state),
        .accept_i    (accept),
        .row_i       (row_i),
        .tall_i      (tall_i),
        .mem_data_i  (mem_data_i),
        .font_rd_o   (font_rd_o),
        .font_addr_o (font_addr_o),
        .font_data_i (font_data_i),
        .idx_o       (text_idx)
    );

    vfetch_bitmap i_bitmap (
        .clk     (clk),
        .rst_n   (rst_n),
        .state_i (state),
        .hi_i    (mem_data_i[6:4]),
        .lo_i    (mem_data_i[2:0]),
        .idx_o   (bm_idx)
    );

    // pixel output selection
    always_comb begin
        pix_valid_o = 1'b0;
        pix_sel_o   = 1'b0;
        pix_rgb_o   = '0;
        pix_idx_o   = '0;
        unique case (state)
            ST_SHIFT: begin
                pix_valid_o = 1'b1;
                pix_sel_o   = 1'b1;
                pix_idx_o   = text_idx;
            end
            ST_PIXA: begin
                pix_valid_o = 1'b1;
                if (hires) begin
                    pix_sel_o = 1'b1;
                    pix_idx_o = bm_idx;
                end else begin
                    pix_rgb_o = mem_data_i;
                end
            end
            ST_PIXB: begin
                pix_valid_o = 1'b1;
                pix_sel_o   = 1'b1;
                pix_idx_o   = bm_idx;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/vfetch_chk.sv
module vfetch_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start_i,
    input logic [7:0] len_i,
    input logic       busy_o,
    input logic       mem_rd_o,
    input logic       font_rd_o,
    input logic       pix_valid_o,
    input logic       pix_sel_o,
    input logic [7:0] pix_rgb_o,
    input logic [2:0] pix_idx_o
);

    assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && len_i != 8'd0) |=> busy_o);

    assert_direct_no_idx_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid_o && !pix_sel_o) |-> (pix_idx_o == 3'd0));

    assert_index_no_rgb_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid_o && pix_sel_o) |-> (pix_rgb_o == 8'd0));

    assert_glyph_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        font_rd_o |=> !pix_valid_o);

    assert_one_port_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_rd_o, font_rd_o}));

    assert_read_when_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_o || pix_valid_o) |-> busy_o);

endmodule

bind vfetch_top vfetch_chk i_vfetch_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .len_i       (len_i),
    .busy_o      (busy_o),
    .mem_rd_o    (mem_rd_o),
    .font_rd_o   (font_rd_o),
    .pix_valid_o (pix_valid_o),
    .pix_sel_o   (pix_sel_o),
    .pix_rgb_o   (pix_rgb_o),
    .pix_idx_o   (pix_idx_o)
);

// File: tb/test_vfetch_top.sv
module test_vfetch_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [1:0]  mode_i = 2'b00;
    logic [7:0]  len_i = 8'd0;
    logic [15:0] base_i = 16'd0;
    logic [3:0]  row_i = 4'd0;
    logic        tall_i = 1'b0;
    logic        mem_rd_o;
    logic [15:0] mem_addr_o;
    logic [7:0]  mem_data_i = 8'd0;
    logic        font_rd_o;
    logic [11:0] font_addr_o;
    logic [7:0]  font_data_i = 8'd0;
    logic        busy_o;
    logic        pix_valid_o;
    logic        pix_sel_o;
    logic [7:0]  pix_rgb_o;
    logic [2:0]  pix_idx_o;

    int n_checks = 0;
    int n_errors = 0;

    logic [7:0]  vmem [0:255];
    logic [11:0] pix_log [$];
    logic [15:0] addr_log [$];
    logic [11:0] font_log [$];

    always #5 clk = ~clk;

    vfetch_top i_vfetch_top (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .mode_i      (mode_i),
        .len_i       (len_i),
        .base_i      (base_i),
        .row_i       (row_i),
        .tall_i      (tall_i),
        .mem_rd_o    (mem_rd_o),
        .mem_addr_o  (mem_addr_o),
        .mem_data_i  (mem_data_i),
        .font_rd_o   (font_rd_o),
        .font_addr_o (font_addr_o),
        .font_data_i (font_data_i),
        .busy_o      (busy_o),
        .pix_valid_o (pix_valid_o),
        .pix_sel_o   (pix_sel_o),
        .pix_rgb_o   (pix_rgb_o),
        .pix_idx_o   (pix_idx_o)
    );

    function automatic logic [7:0] font_fn(input logic [11:0] a);
        logic [11:0] t;
        t = a * 12'd173 + 12'd59;
        return t[7:0] ^ a[11:4];
    endfunction

    // memory models: one clock read latency
    always @(posedge clk) begin
        if (mem_rd_o) mem_data_i <= vmem[mem_addr_o[7:0]];
        if (font_rd_o) font_data_i <= font_fn(font_addr_o);
    end

    // observation away from the active edge
    always @(negedge clk) begin
        if (pix_valid_o) pix_log.push_back({pix_sel_o, pix_rgb_o, pix_idx_o});
        if (mem_rd_o) addr_log.push_back(mem_addr_o);
        if (font_rd_o) font_log.push_back(font_addr_o);
    end

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Run one line; optionally disturb inputs mid-line. Returns busy clocks.
    task automatic run_line(input logic [1:0] m, input logic [15:0] b,
                            input logic [7:0] n, input logic [3:0] r,
                            input logic t, input bit disturb, output int busy_cnt);
        int guard;
        pix_log.delete(); addr_log.delete(); font_log.delete();
        @(negedge clk);
        mode_i = m; base_i = b; len_i = n; row_i = r; tall_i = t; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        busy_cnt = 0;
        guard = 0;
        while (busy_o && guard < 5000) begin
            busy_cnt++;
            guard++;
            if (disturb && busy_cnt == 3) begin
                start_i = 1'b1; mode_i = 2'b00; base_i = 16'h0080;
                len_i = 8'd9; row_i = r + 4'd5; tall_i = ~t;
            end else begin
                start_i = 1'b0;
            end
            @(negedge clk);
        end
        start_i = 1'b0;
        mode_i = m; base_i = b; len_i = n; row_i = r; tall_i = t;
    endtask

    task automatic expect_text(input string req, input logic [15:0] b,
                               input logic [7:0] n, input logic [3:0] r, input logic t);
        logic [3:0] g;
        g = t ? r : {1'b0, r[2:0]};
        check(req, "text pixel count", pix_log.size(), 32'(n) * 8);
        check(req, "text read count", addr_log.size(), 32'(n) * 2);
        check("R6", "glyph read count", font_log.size(), 32'(n));
        for (int k = 0; k < int'(n); k++) begin
            logic [7:0] a, c, gl;
            a = vmem[8'(b + 16'(2 * k))];
            c = vmem[8'(b + 16'(2 * k + 1))];
            gl = font_fn({c, g});
            if (addr_log.size() > 2 * k + 1) begin
                check("R5", "attr address", addr_log[2 * k], b + 16'(2 * k));
                check("R5", "code address", addr_log[2 * k + 1], b + 16'(2 * k + 1));
            end
            if (font_log.size() > k) check("R6", "glyph address", font_log[k], {c, g});
            for (int i = 0; i < 8; i++) begin
                logic [11:0] e;
                e = {1'b1, 8'h00, gl[7 - i] ? a[6:4] : a[2:0]};
                if (pix_log.size() > 8 * k + i) check("R5", "text pixel", pix_log[8 * k + i], e);
            end
        end
    endtask

    task automatic expect_bitmap(input string req, input bit hires,
                                 input logic [15:0] b, input logic [7:0] n);
        int per;
        per = hires ? 2 : 1;
        check(req, "bitmap pixel count", pix_log.size(), 32'(n) * 32'(per));
        check("R9", "bitmap read count", addr_log.size(), 32'(n));
        for (int k = 0; k < int'(n); k++) begin
            logic [7:0] v;
            v = vmem[8'(b + 16'(k))];
            if (addr_log.size() > k) check("R9", "bitmap address", addr_log[k], b + 16'(k));
            if (hires) begin
                if (pix_log.size() > 2 * k + 1) begin
                    check(req, "left nibble pixel", pix_log[2 * k], {1'b1, 8'h00, v[6:4]});
                    check(req, "right nibble pixel", pix_log[2 * k + 1], {1'b1, 8'h00, v[2:0]});
                end
            end else if (pix_log.size() > k) begin
                check(req, "direct pixel", pix_log[k], {1'b0, v, 3'b000});
            end
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1", "busy", busy_o, 0);
        check("R1", "pix_valid", pix_valid_o, 0);
        check("R1", "mem_rd", mem_rd_o, 0);
        check("R1", "font_rd", font_rd_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_lores();
        int bc;
        run_line(2'b00, 16'h0010, 8'd6, 4'd0, 1'b0, 1'b0, bc);
        check("R3", "low-res busy clocks", bc, 12);
        expect_bitmap("R3", 1'b0, 16'h0010, 8'd6);
    endtask

    task automatic t_alt_mode();
        int bc;
        run_line(2'b11, 16'h0033, 8'd3, 4'd0, 1'b0, 1'b0, bc);
        check("R8", "mode 11 busy clocks", bc, 6);
        expect_bitmap("R8", 1'b0, 16'h0033, 8'd3);
    endtask

    task automatic t_hires();
        int bc;
        run_line(2'b10, 16'h0040, 8'd5, 4'd0, 1'b0, 1'b0, bc);
        check("R4", "high-res busy clocks", bc, 15);
        expect_bitmap("R4", 1'b1, 16'h0040, 8'd5);
    endtask

    task automatic t_text_short();
        int bc;
        run_line(2'b01, 16'h0020, 8'd3, 4'd13, 1'b0, 1'b0, bc);
        check("R7", "text busy clocks", bc, 36);
        expect_text("R5", 16'h0020, 8'd3, 4'd13, 1'b0);
    endtask

    task automatic t_text_tall();
        int bc;
        run_line(2'b01, 16'h0051, 8'd4, 4'd13, 1'b1, 1'b0, bc);
        check("R7", "tall text busy clocks", bc, 48);
        expect_text("R6", 16'h0051, 8'd4, 4'd13, 1'b1);
    endtask

    task automatic t_busy_start();
        int bc;
        run_line(2'b01, 16'h0004, 8'd2, 4'd2, 1'b1, 1'b1, bc);
        check("R2", "busy clocks with mid-line start", bc, 24);
        expect_text("R2", 16'h0004, 8'd2, 4'd2, 1'b1);
        repeat (2) @(negedge clk);
        check("R2", "no restart after line", busy_o, 0);
    endtask

    task automatic t_zero_len();
        addr_log.delete(); pix_log.delete();
        @(negedge clk);
        mode_i = 2'b01; len_i = 8'd0; base_i = 16'h0000; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check("R2", "zero length busy", busy_o, 0);
        repeat (4) @(negedge clk);
        check("R2", "zero length reads", addr_log.size(), 0);
        check("R2", "zero length pixels", pix_log.size(), 0);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) vmem[i] = 8'(i * 37 + 11) ^ 8'(i >> 2);
        t_reset();
        t_lores();
        t_alt_mode();
        t_hires();
        t_text_short();
        t_text_tall();
        t_busy_start();
        t_zero_len();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule